// File: doc/BRIEF.md
# Dynamic Loss Scale Controller

This block holds the loss-scaling factor for half-precision training as a power-of-two exponent. During each training step it watches a stream of FP16 gradient words. Several lanes arrive side by side in each valid cycle, and a flag marks the final beat of the step. A word whose exponent field is all ones is a NaN or an infinity. One such word anywhere in the step makes the whole step an overflow.

When a step ends, the block pulses a done strobe. With the strobe it reports whether the optimizer must discard the step, and the exponent to apply next. In dynamic mode an overflow lowers the exponent by one, which halves the scale. A programmable run of consecutive clean steps raises it by one, which doubles the scale. In static mode the exponent is held at a programmed value and no adaptation takes place. Multiplying gradients by the scale, and updating the weights, are left to neighbouring logic.

Top module: `lscale_ctrl`

## Requirements
- R1: During and right after reset, scale_exp reads INIT_EXP (default 16, a scale of 65536), and step_done and skip_step read 0.
- R2: A gradient word is non-finite when its bits [14:10] are all ones. Lane k occupies grad_word[16k+15:16k]. A step overflows if any lane of any beat with grad_valid high is non-finite. Words presented while grad_valid is low have no effect, and a finite word with exponent 11110 does not count.
- R3: step_done is high for exactly the one cycle after each beat with grad_valid and grad_last both high, and is low otherwise. skip_step and the updated scale_exp are valid in that cycle.
- R4: In dynamic mode an overflowed step gives skip_step = 1 and lowers scale_exp by one. It also clears the clean-step count.
- R5: In dynamic mode a clean step gives skip_step = 0. When the clean-step count reaches growth_interval, scale_exp rises by one and the count clears. A growth_interval of 0 behaves as 1.
- R6: scale_exp stays within 0 to MAX_EXP (default 24). An overflow at 0 leaves it at 0, and a growth at MAX_EXP leaves it at MAX_EXP.
- R7: While static_en is high, scale_exp equals static_exp clamped to 3..15 (a scale of 8 to 32768), one cycle after the inputs settle. Steps do not change it. skip_step still reports overflow, and the clean-step count is held at zero.
- R8: The overflow record clears at the end of every step, so a step's result depends only on its own beats.
- R9: After static_en falls, dynamic adaptation continues from the static exponent, with a clean-step count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| static_en | input | 1 | Hold the scale at the programmed exponent |
| static_exp | input | EXP_W | Programmed exponent for static mode |
| growth_interval | input | CNT_W | Clean steps needed before growth |
| grad_valid | input | 1 | Gradient beat present |
| grad_last | input | 1 | This beat ends the step |
| grad_word | input | LANES*16 | FP16 gradient lanes |
| step_done | output | 1 | One-cycle strobe: step result valid |
| skip_step | output | 1 | Step had a NaN or infinity and must be discarded |
| scale_exp | output | EXP_W | Current scale exponent (scale = 2^scale_exp) |

## Verification
Every result is registered once. step_done, skip_step and the new scale_exp all appear in the cycle after the rising edge that takes in the last beat of the step. A change to static_en or static_exp shows on scale_exp one edge later. The bench drives inputs on falling edges. After the final beat it waits exactly one falling edge, which puts the capturing rising edge between drive and sample, and reads all three results there. It then checks one falling edge later that the strobe has dropped. Static-mode values are read one falling edge after the inputs are set.

// File: rtl/lscale_pkg.sv
package lscale_pkg;

    localparam int HALF_W   = 16;
    localparam int HEXP_LSB = 10;
    localparam int HEXP_W   = 5;

    // Half-precision word with an all-ones exponent field: NaN or infinity
    function automatic logic half_nonfinite(input logic [HALF_W-1:0] w);
        return &w[HEXP_LSB +: HEXP_W];
    endfunction

endpackage

// File: rtl/lscale_lane_check.sv
module lscale_lane_check
    import lscale_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*HALF_W-1:0] words,
    output logic                    any_bad
);

    logic [LANES-1:0] lane_bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bad[g] = half_nonfinite(words[g*HALF_W +: HALF_W]);
    end

    assign any_bad = |lane_bad;

endmodule

// File: rtl/lscale_step_track.sv
module lscale_step_track (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_last,
    input  logic beat_bad,
    output logic end_evt,
    output logic end_ovf
);

    typedef struct packed {
        logic sticky;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d   = trk_q;
        end_evt = beat_valid && beat_last;
        end_ovf = trk_q.sticky || beat_bad;
        if (beat_valid) begin
            trk_d.sticky = beat_last ? 1'b0 : (trk_q.sticky || beat_bad);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R8: record is empty after every step end
    p_record_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> !trk_q.sticky);

    // R2: a bad valid beat that does not end the step is remembered
    p_bad_remembered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_bad && !beat_last) |=> trk_q.sticky);

endmodule

// File: rtl/lscale_scale_ctrl.sv
module lscale_scale_ctrl #(
    parameter int EXP_W    = 5,
    parameter int CNT_W    = 16,
    parameter int INIT_EXP = 16,
    parameter int MAX_EXP  = 24,
    parameter int STAT_MIN = 3,
    parameter int STAT_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_evt,
    input  logic             end_ovf,
    input  logic             static_en,
    input  logic [EXP_W-1:0] static_exp,
    input  logic [CNT_W-1:0] grow_after,
    output logic             done,
    output logic             skip,
    output logic [EXP_W-1:0] exp_out
);

    localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(MAX_EXP);
    localparam logic [EXP_W-1:0] EXP_RST  = EXP_W'(INIT_EXP);
    localparam logic [EXP_W-1:0] SEXP_LO  = EXP_W'(STAT_MIN);
    localparam logic [EXP_W-1:0] SEXP_HI  = EXP_W'(STAT_MAX);

    typedef struct packed {
        logic             done;
        logic             skip;
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [EXP_W-1:0] stat_val;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   grow_lim;

    always_comb begin
        if (static_exp < SEXP_LO) begin
            stat_val = SEXP_LO;
        end else if (static_exp > SEXP_HI) begin
            stat_val = SEXP_HI;
        end else begin
            stat_val = static_exp;
        end
        cnt_inc  = {1'b0, ctl_q.cnt} + 1'b1;
        grow_lim = (grow_after == '0) ? (CNT_W+1)'(1) : {1'b0, grow_after};

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.skip = 1'b0;

        if (static_en) begin
            ctl_d.exp = stat_val;
            ctl_d.cnt = '0;
            if (end_evt) begin
                ctl_d.done = 1'b1;
                ctl_d.skip = end_ovf;
            end
        end else if (end_evt) begin
            ctl_d.done = 1'b1;
            ctl_d.skip = end_ovf;
            if (end_ovf) begin
                ctl_d.cnt = '0;
                if (ctl_q.exp != '0) begin
                    ctl_d.exp = ctl_q.exp - 1'b1;
                end
            end else if (cnt_inc >= grow_lim) begin
                ctl_d.cnt = '0;
                if (ctl_q.exp < EXP_TOP) begin
                    ctl_d.exp = ctl_q.exp + 1'b1;
                end
            end else begin
                ctl_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.exp  <= EXP_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done    = ctl_q.done;
    assign skip    = ctl_q.skip;
    assign exp_out = ctl_q.exp;

    // R4: overflow in dynamic mode backs off by one step
    p_backoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && end_ovf && !static_en && ctl_q.exp != '0)
            |=> (ctl_q.exp == $past(ctl_q.exp) - 1'b1) && (ctl_q.cnt == '0));

    // R6: exponent never leaves its range
    p_exp_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.exp <= EXP_TOP);

    // R6: back-off at the floor holds the floor
    p_floor_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && end_ovf && !static_en && ctl_q.exp == '0) |=> ctl_q.exp == '0);

    // R5: a clean step never lowers the exponent in dynamic mode
    p_clean_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && !end_ovf && !static_en) |=> ctl_q.exp >= $past(ctl_q.exp));

    // R7: stable static inputs keep the exponent stable
    p_static_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (static_en && $stable(static_en) && $stable(static_exp)) |=> $stable(ctl_q.exp));

    // R7: count held at zero in static mode
    p_static_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        static_en |=> ctl_q.cnt == '0);

endmodule

// File: rtl/lscale_ctrl.sv
module lscale_ctrl
    import lscale_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int EXP_W    = 5,
    parameter int CNT_W    = 16,
    parameter int INIT_EXP = 16,
    parameter int MAX_EXP  = 24,
    parameter int STAT_MIN = 3,
    parameter int STAT_MAX = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    static_en,
    input  logic [EXP_W-1:0]        static_exp,
    input  logic [CNT_W-1:0]        growth_interval,
    input  logic                    grad_valid,
    input  logic                    grad_last,
    input  logic [LANES*HALF_W-1:0] grad_word,
    output logic                    step_done,
    output logic                    skip_step,
    output logic [EXP_W-1:0]        scale_exp
);

    logic beat_bad;
    logic end_evt;
    logic end_ovf;

    lscale_lane_check #(
        .LANES (LANES)
    ) u_check (
        .words   (grad_word),
        .any_bad (beat_bad)
    );

    lscale_step_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (grad_valid),
        .beat_last  (grad_last),
        .beat_bad   (beat_bad),
        .end_evt    (end_evt),
        .end_ovf    (end_ovf)
    );

    lscale_scale_ctrl #(
        .EXP_W    (EXP_W),
        .CNT_W    (CNT_W),
        .INIT_EXP (INIT_EXP),
        .MAX_EXP  (MAX_EXP),
        .STAT_MIN (STAT_MIN),
        .STAT_MAX (STAT_MAX)
    ) u_scale (
        .clk        (clk),
        .rst_n      (rst_n),
        .end_evt    (end_evt),
        .end_ovf    (end_ovf),
        .static_en  (static_en),
        .static_exp (static_exp),
        .grow_after (growth_interval),
        .done       (step_done),
        .skip       (skip_step),
        .exp_out    (scale_exp)
    );

    // R3: every closing beat yields a strobe next cycle
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grad_valid && grad_last) |=> step_done);

    // R3: no strobe without a closing beat
    p_no_stray_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(grad_valid && grad_last) |=> !step_done);

    // R4: skip only accompanies a strobe
    p_skip_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        skip_step |-> step_done);

    // R3: exponent moves only on a strobe or in static mode
    p_exp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(grad_valid && grad_last) && !static_en) |=> $stable(scale_exp));

endmodule

// File: tb/lscale_ctrl_test.sv
module lscale_ctrl_test;

    localparam int LANES = 2;
    localparam int EXP_W = 5;
    localparam int CNT_W = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   static_en = 1'b0;
    logic [EXP_W-1:0]       static_exp = '0;
    logic [CNT_W-1:0]       growth_interval = '0;
    logic                   grad_valid = 1'b0;
    logic                   grad_last = 1'b0;
    logic [LANES*16-1:0]    grad_word = '0;
    logic                   step_done;
    logic                   skip_step;
    logic [EXP_W-1:0]       scale_exp;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lscale_ctrl #(.LANES(LANES), .EXP_W(EXP_W), .CNT_W(CNT_W)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .static_en       (static_en),
        .static_exp      (static_exp),
        .growth_interval (growth_interval),
        .grad_valid      (grad_valid),
        .grad_last       (grad_last),
        .grad_word       (grad_word),
        .step_done       (step_done),
        .skip_step       (skip_step),
        .scale_exp       (scale_exp)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        static_en = 1'b0;
        grad_valid = 1'b0;
        grad_last = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One step of nwords beats; bad_at < 0 means all words finite.
    // Leaves sampled results one cycle after the last beat.
    task automatic run_step(input int nwords, input int bad_at, input int bad_lane,
                            input logic [15:0] bad_word,
                            output logic done_o, output logic skip_o,
                            output logic [EXP_W-1:0] exp_o);
        for (int w = 0; w < nwords; w++) begin
            @(negedge clk);
            grad_valid = 1'b1;
            grad_last  = (w == nwords - 1);
            for (int l = 0; l < LANES; l++) begin
                grad_word[l*16 +: 16] = 16'h3C00 + 16'(w + l);
            end
            if (w == bad_at) grad_word[bad_lane*16 +: 16] = bad_word;
        end
        @(negedge clk);
        grad_valid = 1'b0;
        grad_last  = 1'b0;
        done_o = step_done;
        skip_o = skip_step;
        exp_o  = scale_exp;
        @(negedge clk);
        chk("R3 strobe drops", int'(step_done), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 exp in reset", int'(scale_exp), 16);
        chk("R1 done in reset", int'(step_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 exp after reset", int'(scale_exp), 16);
        chk("R1 skip after reset", int'(skip_step), 0);
    endtask

    task automatic t_growth();
        logic d, s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 3;
        run_step(2, -1, 0, 16'h0, d, s, e);
        chk("R3 done after last", int'(d), 1);
        chk("R5 clean skip", int'(s), 0);
        chk("R5 no early growth", int'(e), 16);
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R5 no early growth 2", int'(e), 16);
        run_step(3, -1, 0, 16'h0, d, s, e);
        chk("R5 growth at interval", int'(e), 17);
        for (int i = 0; i < 3; i++) run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R5 second growth", int'(e), 18);
    endtask

    task automatic t_overflow();
        logic d, s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 3;
        run_step(1, -1, 0, 16'h0, d, s, e);
        run_step(1, -1, 0, 16'h0, d, s, e);
        run_step(3, 1, 0, 16'h7C00, d, s, e);
        chk("R4 skip on inf", int'(s), 1);
        chk("R4 halve on inf", int'(e), 15);
        run_step(1, -1, 0, 16'h0, d, s, e);
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R4 count cleared", int'(e), 15);
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R5 growth after backoff", int'(e), 16);
    endtask

    task automatic t_lanes();
        logic d, s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 100;
        run_step(2, 1, LANES - 1, 16'hFE00, d, s, e);
        chk("R2 NaN high lane last beat", int'(s), 1);
        chk("R2 exp after NaN", int'(e), 15);
        run_step(2, 0, 1, 16'h7BFF, d, s, e);
        chk("R2 max finite not bad", int'(s), 0);
        chk("R2 exp after finite", int'(e), 15);
    endtask

    task automatic t_ignored();
        logic s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 100;
        @(negedge clk);
        grad_valid = 1'b1; grad_last = 1'b0; grad_word = {16'h3C00, 16'h3C00};
        @(negedge clk);
        grad_valid = 1'b0; grad_word = {16'h7C00, 16'hFFFF};
        @(negedge clk);
        grad_valid = 1'b1; grad_last = 1'b1; grad_word = {16'h4000, 16'h4000};
        @(negedge clk);
        grad_valid = 1'b0; grad_last = 1'b0;
        s = skip_step; e = scale_exp;
        chk("R2 idle NaN ignored skip", int'(s), 0);
        chk("R2 idle NaN ignored exp", int'(e), 16);
    endtask

    task automatic t_sticky();
        logic d, s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 100;
        run_step(4, 0, 0, 16'hFC00, d, s, e);
        chk("R8 early overflow held", int'(s), 1);
        run_step(3, -1, 0, 16'h0, d, s, e);
        chk("R8 next step clean", int'(s), 0);
        chk("R8 exp unchanged", int'(e), 15);
    endtask

    task automatic t_interval_zero();
        logic d, s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 0;
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R5 interval zero grows", int'(e), 17);
        run_step(2, -1, 0, 16'h0, d, s, e);
        chk("R5 interval zero grows again", int'(e), 18);
    endtask

    task automatic t_clamp();
        logic d, s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 1;
        for (int i = 0; i < 8; i++) run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R6 reach ceiling", int'(e), 24);
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R6 ceiling holds", int'(e), 24);
        do_reset();
        for (int i = 0; i < 16; i++) run_step(1, 0, 0, 16'h7C00, d, s, e);
        chk("R6 reach floor", int'(e), 0);
        run_step(1, 0, 1, 16'h7E01, d, s, e);
        chk("R6 floor holds", int'(e), 0);
        chk("R4 skip at floor", int'(s), 1);
    endtask

    task automatic t_static();
        logic d, s; logic [EXP_W-1:0] e;
        do_reset();
        growth_interval = 1;
        @(negedge clk);
        static_en = 1'b1; static_exp = 10;
        @(negedge clk);
        chk("R7 static load", int'(scale_exp), 10);
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R7 no growth", int'(e), 10);
        run_step(2, 1, 0, 16'h7C00, d, s, e);
        chk("R7 skip still reported", int'(s), 1);
        chk("R7 no backoff", int'(e), 10);
        static_exp = 20;
        @(negedge clk);
        chk("R7 clamp high", int'(scale_exp), 15);
        static_exp = 1;
        @(negedge clk);
        chk("R7 clamp low", int'(scale_exp), 3);
        static_exp = 10;
        @(negedge clk);
        growth_interval = 2;
        static_en = 1'b0;
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R9 resume from static", int'(e), 10);
        run_step(1, -1, 0, 16'h0, d, s, e);
        chk("R9 grows after resume", int'(e), 11);
        run_step(1, 0, 0, 16'h7C00, d, s, e);
        chk("R9 backoff after resume", int'(e), 10);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog R3 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_growth();
        t_overflow();
        t_lanes();
        t_ignored();
        t_sticky();
        t_interval_zero();
        t_clamp();
        t_static();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule